// File: doc/BRIEF.md
# Triplicated Register Bank with Per-Copy Scan Chains

This block is a bank of W register bits hardened against single upsets. Every bit lives in three flip-flop copies. Copy k is clocked by member k of a three-wire clock bundle and cleared by member k of a three-wire reset bundle. The value seen at the output is the bitwise two-of-three majority of the copies. When the load enable is low, each copy reloads the voted value instead of its own contents. A single corrupted copy is therefore rewritten with the correct value on the next edge, whether or not new data is being loaded.

For manufacturing test, a scan mode threads the copies into three separate shift chains, one per clock member. No shift path runs from a flip-flop on one clock member to a flip-flop on another, so the chains tolerate the small skew between the members. A mismatch flag reports any bit whose three copies disagree. A test-only force port inverts one chosen copy of one chosen bit on the next edge, so that the voting and repair paths can be exercised.

Each copy runs in one of three modes: HOLD (enable low, reload the voted value), LOAD (enable high, take the data input) or SHIFT (scan enable high, take the scan predecessor). The mode is decided once per edge from the enable and scan enable. SHIFT has the highest priority, then LOAD, then HOLD.

Top module: `tmr_reg_bank`

## Requirements
- R1: While reset member k is low, copy k of every bit is zero. It does not affect the other two copies. With all reset members low, q is 0, mismatch is 0 and scan_out is 0.
- R2: With scan_en low and en high, after the edges of one cycle every copy, and therefore q, equals d.
- R3: With scan_en low and en low, each copy loads the current voted value. A q with no disagreement stays unchanged and d has no effect.
- R4: q[i] is the majority of the three copies of bit i. A single copy that differs never changes q.
- R5: After a cycle with scan_en low and force_en low, all three copies agree again, in both HOLD and LOAD. A single flipped copy is therefore repaired by one edge.
- R6: mismatch is high exactly when at least one bit has copies that do not all agree.
- R7: With scan_en high, en and d are ignored. Copy k of bit 0 loads scan_in[k], and copy k of bit i loads copy k of bit i-1. scan_out[k] is copy k of bit W-1. The three chains never exchange data.
- R8: With force_en high and scan_en low, copy force_copy (0, 1 or 2) of bit force_bit loads the inverse of the value it would otherwise load. All other copies and bits are unaffected. force_en has no effect in scan mode.
- R9: Capture is correct when clock member 1 lags member 0 and member 2 lags member 1 by a small skew, well below half a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 3 | Clock bundle; member k clocks copy k |
| rst_n | input | 3 | Active-low asynchronous reset bundle; member k clears copy k |
| en | input | 1 | Load enable; high loads d, low reloads the voted value |
| d | input | W | Parallel data in |
| scan_en | input | 1 | Scan shift mode, overrides en and d |
| scan_in | input | 3 | Serial input of chain k |
| force_en | input | 1 | Test-only: invert one copy of one bit on the next edge |
| force_copy | input | 2 | Copy selected for inversion (0..2) |
| force_bit | input | clog2(W) | Bit selected for inversion |
| q | output | W | Voted register value |
| scan_out | output | 3 | Serial output of chain k (copy k of bit W-1) |
| mismatch | output | 1 | High while any bit has disagreeing copies |

## Verification
On every clock member, the in-line assertions check the per-copy behaviour: LOAD takes d, HOLD takes the voted value, SHIFT moves the chain by one place and reset clears the copy. On the first member, an assertion checks that any cycle with scan and force inactive leaves no disagreement. Some effects only appear as a sequence at the ports, and these are shown by the bench's scenarios. One is the majority masking a single forced copy while mismatch rises and is then repaired. Another is a lone reset member clearing one copy without moving q. A third is three distinct scan patterns landing in three independent chains and producing a mixed vote. The bench also runs the whole sequence of modes under skewed clock members.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_SHIFT = 2'd2
    } lane_mode_e;

    localparam int NUM_COPIES = 3;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/tmr_mode_sel.sv
`timescale 1ns/1ps
module tmr_mode_sel
    import tmr_pkg::*;
(
    input  logic       en,
    input  logic       scan_en,
    output lane_mode_e mode
);

    always_comb begin
        unique case ({scan_en, en})
            2'b10, 2'b11: mode = MODE_SHIFT;
            2'b01:        mode = MODE_LOAD;
            default:      mode = MODE_HOLD;
        endcase
    end

endmodule

// File: rtl/tmr_voter.sv
`timescale 1ns/1ps
module tmr_voter
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] cp0,
    input  logic [W-1:0] cp1,
    input  logic [W-1:0] cp2,
    output logic [W-1:0] voted,
    output logic         mismatch
);

    logic [W-1:0] differ;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign voted[i]  = maj3(cp0[i], cp1[i], cp2[i]);
        assign differ[i] = (cp0[i] ^ cp1[i]) | (cp0[i] ^ cp2[i]);
    end

    assign mismatch = |differ;

endmodule

// File: rtl/tmr_lane.sv
`timescale 1ns/1ps
module tmr_lane
    import tmr_pkg::*;
#(
    parameter int W    = 8,
    parameter int IDXW = (W > 1) ? $clog2(W) : 1,
    parameter int LANE = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  lane_mode_e      mode,
    input  logic [W-1:0]    d,
    input  logic [W-1:0]    voted,
    input  logic            scan_in,
    input  logic            force_en,
    input  logic [1:0]      force_copy,
    input  logic [IDXW-1:0] force_bit,
    output logic [W-1:0]    copy
);

    localparam logic [1:0] LANE_ID = 2'(LANE);

    logic [W-1:0] base_nxt;
    logic [W-1:0] flip_mask;
    logic [W-1:0] copy_nxt;
    logic         force_hit;

    assign force_hit = force_en && (mode != MODE_SHIFT) && (force_copy == LANE_ID);

    always_comb begin
        unique case (mode)
            MODE_SHIFT: base_nxt = {copy[W-2:0], scan_in};
            MODE_LOAD:  base_nxt = d;
            default:    base_nxt = voted;
        endcase
    end

    always_comb begin
        for (int i = 0; i < W; i++) begin
            flip_mask[i] = force_hit && (force_bit == IDXW'(i));
        end
    end

    assign copy_nxt = base_nxt ^ flip_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) copy <= '0;
        else        copy <= copy_nxt;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |-> copy == '0); // R1

    AST_LOAD_TAKES_D: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOAD && !(force_en && force_copy == LANE_ID)) |=> copy == $past(d)); // R2

    AST_HOLD_TAKES_VOTE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD && !force_en) |=> copy == $past(voted)); // R3

    AST_SHIFT_ONE_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SHIFT) |=> copy == {$past(copy[W-2:0]), $past(scan_in)}); // R7

endmodule

// File: rtl/tmr_reg_bank.sv
`timescale 1ns/1ps
module tmr_reg_bank
    import tmr_pkg::*;
#(
    parameter int W    = 8,
    parameter int IDXW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [2:0]      clk,
    input  logic [2:0]      rst_n,
    input  logic            en,
    input  logic [W-1:0]    d,
    input  logic            scan_en,
    input  logic [2:0]      scan_in,
    input  logic            force_en,
    input  logic [1:0]      force_copy,
    input  logic [IDXW-1:0] force_bit,
    output logic [W-1:0]    q,
    output logic [2:0]      scan_out,
    output logic            mismatch
);

    lane_mode_e   mode;
    logic [W-1:0] voted;
    logic [W-1:0] copy_q [NUM_COPIES];

    tmr_mode_sel u_mode (
        .en      (en),
        .scan_en (scan_en),
        .mode    (mode)
    );

    for (genvar k = 0; k < NUM_COPIES; k++) begin : g_lane
        tmr_lane #(.W(W), .IDXW(IDXW), .LANE(k)) u_lane (
            .clk        (clk[k]),
            .rst_n      (rst_n[k]),
            .mode       (mode),
            .d          (d),
            .voted      (voted),
            .scan_in    (scan_in[k]),
            .force_en   (force_en),
            .force_copy (force_copy),
            .force_bit  (force_bit),
            .copy       (copy_q[k])
        );
        assign scan_out[k] = copy_q[k][W-1];
    end

    tmr_voter #(.W(W)) u_vote (
        .cp0      (copy_q[0]),
        .cp1      (copy_q[1]),
        .cp2      (copy_q[2]),
        .voted    (voted),
        .mismatch (mismatch)
    );

    assign q = voted;

    AST_AGREE_AFTER_CLEAN_CYCLE: assert property (@(posedge clk[0]) disable iff (!(&rst_n))
        (!scan_en && !force_en) |=> !mismatch); // R5

endmodule

// File: tb/sim_tmr_reg_bank.sv
`timescale 1ns/1ps
module sim_tmr_reg_bank;

    localparam int W    = 8;
    localparam int IDXW = $clog2(W);

    logic c0 = 1'b0, c1 = 1'b0, c2 = 1'b0;
    logic [2:0]      clk;
    logic [2:0]      rst_n = 3'b000;
    logic            en = 1'b0, scan_en = 1'b0, force_en = 1'b0;
    logic [W-1:0]    d = '0;
    logic [2:0]      scan_in = '0;
    logic [1:0]      force_copy = '0;
    logic [IDXW-1:0] force_bit = '0;
    logic [W-1:0]    q;
    logic [2:0]      scan_out;
    logic            mismatch;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] m [3];

    assign clk = {c2, c1, c0};

    always #5 c0 = ~c0;                     // 100 MHz
    always @(c0) begin #0.4; c1 = c0; end   // R9 skew
    always @(c0) begin #0.8; c2 = c0; end

    tmr_reg_bank #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .d(d), .scan_en(scan_en),
        .scan_in(scan_in), .force_en(force_en), .force_copy(force_copy),
        .force_bit(force_bit), .q(q), .scan_out(scan_out), .mismatch(mismatch)
    );

    function automatic logic [W-1:0] vote(input logic [W-1:0] a, b, c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic disagree(input logic [W-1:0] a, b, c);
        return (a != b) || (a != c);
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, q, vote(m[0], m[1], m[2]));
        chk("R6 mismatch", W'(mismatch), W'(disagree(m[0], m[1], m[2])));
        chk("R7 scan_out", W'(scan_out), W'({m[2][W-1], m[1][W-1], m[0][W-1]}));
    endtask

    task automatic step(input logic e, input logic se, input logic [W-1:0] dv,
                        input logic [2:0] si, input logic fe, input logic [1:0] fc,
                        input int fb, input string tag);
        logic [W-1:0] nx [3];
        logic [W-1:0] v;
        @(negedge c0);
        en = e; scan_en = se; d = dv; scan_in = si;
        force_en = fe; force_copy = fc; force_bit = IDXW'(fb);
        v = vote(m[0], m[1], m[2]);
        for (int k = 0; k < 3; k++) begin
            if (se)     nx[k] = {m[k][W-2:0], si[k]};
            else if (e) nx[k] = dv;
            else        nx[k] = v;
            if (fe && !se && fc == 2'(k)) nx[k][fb] = ~nx[k][fb];
        end
        @(posedge c0);
        #2;
        for (int k = 0; k < 3; k++) m[k] = nx[k];
        check_all(tag);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] pat [3];
        void'($urandom(32'd4242));
        for (int k = 0; k < 3; k++) m[k] = '0;
        repeat (3) @(posedge c0);
        #2;
        check_all("R1 reset");
        @(negedge c0);
        rst_n = 3'b111;

        // R2 load, R3 hold ignores d
        step(1, 0, 8'hA5, 0, 0, 0, 0, "R2 load");
        step(0, 0, 8'h3C, 0, 0, 0, 0, "R3 hold");
        chk("R3 hold keeps value", q, 8'hA5);

        // R8 force, R4 masked, R5 repair on idle edge
        step(0, 0, 8'hFF, 0, 1, 2'd1, 3, "R8 force idle");
        chk("R4 single flip masked", q, 8'hA5);
        chk("R6 flag after force", W'(mismatch), W'(1));
        step(0, 0, 8'h00, 0, 0, 0, 0, "R5 idle repair");
        chk("R5 flag clear", W'(mismatch), W'(0));

        // R5 repair on enabled edge
        step(0, 0, 8'h00, 0, 1, 2'd2, 7, "R8 force copy2");
        step(1, 0, 8'h5A, 0, 0, 0, 0, "R5 load repair");
        chk("R5 load value", q, 8'h5A);

        // R1 single reset member clears only its copy
        @(negedge c0);
        en = 0; rst_n[2] = 1'b0; m[2] = '0;
        @(posedge c0);
        #2;
        check_all("R1 member reset");
        chk("R1 q unmoved", q, 8'h5A);
        @(negedge c0);
        rst_n[2] = 1'b1;
        step(0, 0, 8'h00, 0, 0, 0, 0, "R5 repair after reset");

        // R7 scan: three independent patterns, en/d ignored
        pat[0] = 8'hF0; pat[1] = 8'hCC; pat[2] = 8'hAA;
        for (int i = W - 1; i >= 0; i--) begin
            step(1, 1, W'($urandom), {pat[2][i], pat[1][i], pat[0][i]},
                 1, 2'd0, 0, "R7 shift");
        end
        chk("R7 chain0", m[0], 8'hF0);
        chk("R4 mixed vote", q, 8'hE8);
        step(0, 0, 8'h00, 0, 0, 0, 0, "R5 vote settles");
        chk("R5 settled vote", q, 8'hE8);

        // constrained random under skew
        for (int i = 0; i < 400; i++) begin
            int r;
            logic se, e, fe;
            r  = $urandom;
            se = (r % 8) == 0;
            e  = r[5];
            fe = r[9:8] == 2'b11 && !disagree(m[0], m[1], m[2]);
            step(e, se, W'($urandom), 3'($urandom), fe, 2'($urandom % 3),
                 int'($urandom % W), "R9 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule